// File: doc/BRIEF.md
# Video Overlay Color Blender

This block mixes one of seven programmable overlay colors into a 4:4:4 YCbCr pixel stream, one pixel per valid beat. Each pixel carries a 3-bit overlay select: code 0 keeps the incoming pixel, and codes 1 to 7 name an entry of the overlay color table. A 2-bit mode input chooses how the two sources meet.

- **Hard-switch mode** replaces the pixel outright.
- **External mode** takes a four-level blend ratio from a pair of mix pins on every pixel.
- **Internal mode** ignores the mix pins. It cross-fades automatically in two steps, 1/8 and 7/8, around every change of select. The first step lands on the pixel before the change.

To see the pixel after the current one, the block holds each accepted pixel in a one-beat delay register. It emits that pixel only once its successor has been accepted, and it does this in every mode, so output timing never depends on the mode.

A small ramp-phase state machine tracks the held pixel. It has three states:

| State | Meaning |
|---|---|
| `PH_EMPTY` | Nothing has been held since reset. |
| `PH_STEADY` | The held select equals its predecessor's select. |
| `PH_SETTLE` | The held select differs from its predecessor's select. |

Its transitions are:

- **first-accept**: `PH_EMPTY` to `PH_STEADY` or `PH_SETTLE`, with the predecessor taken as code 0.
- **same-select**: any held state to `PH_STEADY`, when the incoming select equals the held one.
- **select-change**: any held state to `PH_SETTLE`, when the incoming select differs from the held one.
- **idle-hold**: the state stays put on a cycle without a valid beat.

Top module: `ovl_blend`

## Requirements
- R1: While reset is low and after its release, `out_valid` is 0 and `out_pix` is 0 until the first output beat.
- R2: An accepted pixel is emitted with `out_valid` high in the clock cycle right after the next pixel is accepted. The mode in force on the cycle that accepts that next pixel governs the blend. `out_valid` is low in every other cycle, and `out_pix` keeps its value whenever `out_valid` is low.
- R3: Pixels and colors pack as {Y[23:16], Cb[15:8], Cr[7:0]}. Overlay color i (1..7) occupies bits [(i-1)*24 +: 24] of `ovl_colors`. Each blend computes, per component, (k*A + (8-k)*B + 4) >> 3 with k in {0,1,7,8}.
- R4: In mode 2'b00 (hard switch), and in mode 2'b11 which behaves the same way, select 0 outputs the pixel unchanged and a nonzero select outputs its color exactly. The mix pins have no effect, and there is no minimum run length.
- R5: In mode 2'b01 (external), the held pixel's mix code sets the overlay weight k: 00 gives 0, 01 gives 1, 10 gives 7 and 11 gives 8. A is the selected color and B the pixel. The code may change on any pixel, and select 0 always outputs the pixel.
- R6: In mode 2'b10 (internal), when the held select equals its predecessor but differs from the next select, the output is 1/8 of the next source plus 7/8 of the held source. A source of code 0 means the held pixel itself.
- R7: In internal mode, when the held select differs from its predecessor, the output is 7/8 of the held source plus 1/8 of the predecessor's source. This step takes priority over R6. The predecessor of the first pixel after reset counts as code 0.
- R8: In internal mode, when the held select equals both its predecessor and its successor, the output is the held source unblended, and the mix pins have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Pixel beat strobe |
| pix_in | input | 24 | Input pixel {Y, Cb, Cr} |
| ovl_sel | input | 3 | Overlay select, 0 means pixel |
| mix_code | input | 2 | External blend ratio code |
| mode | input | 2 | 00 hard switch, 01 external, 10 internal, 11 as hard switch |
| ovl_colors | input | 168 | Seven overlay colors, color i at bits [(i-1)*24 +: 24] |
| out_valid | output | 1 | Output beat strobe |
| out_pix | output | 24 | Blended pixel {Y, Cb, Cr} |

## Verification
A wrong ramp phase or a stale predecessor select shows up on the very next output beat: the pixel around a select change comes out unblended, or it is blended against the wrong neighbour. A misaligned delay register shifts every output by one beat. It therefore fails the first check after any pixel that differs from its neighbour. A slip in weight decode or lane arithmetic appears as an error of at least one code in a component on the first beat that uses the affected weight.

// File: rtl/ovl_blend_pkg.sv
package ovl_blend_pkg;

    typedef enum logic [1:0] {
        MODE_HARD = 2'b00,
        MODE_EXT  = 2'b01,
        MODE_INT  = 2'b10,
        MODE_RSVD = 2'b11
    } mix_mode_e;

    typedef enum logic [1:0] {
        PH_EMPTY  = 2'b00,
        PH_STEADY = 2'b01,
        PH_SETTLE = 2'b10
    } ramp_phase_e;

    localparam int WT_W = 4;
    localparam logic [WT_W-1:0] WT_NONE = 4'd0;
    localparam logic [WT_W-1:0] WT_LOW  = 4'd1;
    localparam logic [WT_W-1:0] WT_HIGH = 4'd7;
    localparam logic [WT_W-1:0] WT_FULL = 4'd8;

    // weight given to the overlay source for an external mix code
    function automatic logic [WT_W-1:0] code_weight(input logic [1:0] code);
        logic [WT_W-1:0] w;
        unique case (code)
            2'b00:   w = WT_NONE;
            2'b01:   w = WT_LOW;
            2'b10:   w = WT_HIGH;
            default: w = WT_FULL;
        endcase
        return w;
    endfunction

endpackage

// File: rtl/ovl_mix_lane.sv
module ovl_mix_lane #(
    parameter int COMP_W = 8
) (
    input  logic [ovl_blend_pkg::WT_W-1:0] wt,
    input  logic [COMP_W-1:0]              comp_a,
    input  logic [COMP_W-1:0]              comp_b,
    output logic [COMP_W-1:0]              comp_y
);
    localparam int SUM_W = COMP_W + ovl_blend_pkg::WT_W;

    logic [SUM_W-1:0] wt_a;
    logic [SUM_W-1:0] wt_b;
    logic [SUM_W-1:0] acc;

    always_comb begin
        wt_a   = SUM_W'(wt);
        wt_b   = SUM_W'(ovl_blend_pkg::WT_FULL) - SUM_W'(wt);
        acc    = wt_a * SUM_W'(comp_a) + wt_b * SUM_W'(comp_b) + SUM_W'(4);
        comp_y = acc[COMP_W+2:3];
    end

endmodule

// File: rtl/ovl_color_pick.sv
module ovl_color_pick #(
    parameter int COMP_W  = 8,
    parameter int NUM_OVL = 7,
    parameter int SEL_W   = 3
) (
    input  logic [SEL_W-1:0]            code,
    input  logic [3*COMP_W-1:0]         held_pix,
    input  logic [NUM_OVL*3*COMP_W-1:0] color_tbl,
    output logic [3*COMP_W-1:0]         color
);
    localparam int PIX_W = 3 * COMP_W;

    always_comb begin
        color = held_pix;
        for (int i = 1; i <= NUM_OVL; i++) begin
            if (code == SEL_W'(i)) begin
                color = color_tbl[(i-1)*PIX_W +: PIX_W];
            end
        end
    end

endmodule

// File: rtl/ovl_ramp_ctrl.sv
module ovl_ramp_ctrl
    import ovl_blend_pkg::*;
#(
    parameter int SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             accept,
    input  logic [SEL_W-1:0] in_sel,
    input  logic [1:0]       in_mix,
    input  logic [1:0]       mode,
    output logic             held_ok,
    output logic [SEL_W-1:0] held_sel,
    output logic [SEL_W-1:0] prev_sel,
    output logic [1:0]       held_mix,
    output logic [WT_W-1:0]  wt,
    output logic [SEL_W-1:0] sel_a,
    output logic [SEL_W-1:0] sel_b
);
    ramp_phase_e phase;
    ramp_phase_e phase_nxt;
    mix_mode_e   mode_e;

    assign mode_e  = mix_mode_e'(mode);
    assign held_ok = (phase != PH_EMPTY);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= PH_EMPTY;
        end else begin
            phase <= phase_nxt;
        end
    end

    // held select, predecessor select and mix code
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held_sel <= '0;
            prev_sel <= '0;
            held_mix <= 2'b00;
        end else if (accept) begin
            held_sel <= in_sel;
            prev_sel <= held_sel;
            held_mix <= in_mix;
        end
    end

    // transitions
    always_comb begin
        phase_nxt = phase;
        unique case (phase)
            PH_EMPTY: begin
                if (accept) begin
                    phase_nxt = (in_sel != '0) ? PH_SETTLE : PH_STEADY;
                end
            end
            PH_STEADY, PH_SETTLE: begin
                if (accept) begin
                    phase_nxt = (in_sel != held_sel) ? PH_SETTLE : PH_STEADY;
                end
            end
            default: phase_nxt = PH_EMPTY;
        endcase
    end

    // blend weight and source selection
    always_comb begin
        wt    = WT_FULL;
        sel_a = held_sel;
        sel_b = '0;
        unique case (mode_e)
            MODE_EXT: begin
                wt = code_weight(held_mix);
            end
            MODE_INT: begin
                unique case (phase)
                    PH_SETTLE: begin
                        wt    = WT_HIGH;
                        sel_b = prev_sel;
                    end
                    PH_STEADY: begin
                        if (in_sel != held_sel) begin
                            wt    = WT_LOW;
                            sel_a = in_sel;
                            sel_b = held_sel;
                        end
                    end
                    default: begin
                        wt = WT_FULL;
                    end
                endcase
            end
            default: begin
                wt = WT_FULL;
            end
        endcase
    end

endmodule

// File: rtl/ovl_blend.sv
module ovl_blend #(
    parameter int COMP_W  = 8,
    parameter int NUM_OVL = 7
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic                                   in_valid,
    input  logic [3*COMP_W-1:0]                    pix_in,
    input  logic [$clog2(NUM_OVL+1)-1:0]           ovl_sel,
    input  logic [1:0]                             mix_code,
    input  logic [1:0]                             mode,
    input  logic [NUM_OVL*3*COMP_W-1:0]            ovl_colors,
    output logic                                   out_valid,
    output logic [3*COMP_W-1:0]                    out_pix
);
    localparam int SEL_W   = $clog2(NUM_OVL + 1);
    localparam int NUM_CMP = 3;
    localparam int PIX_W   = NUM_CMP * COMP_W;
    localparam int NUM_SRC = 2;

    logic                          held_ok;
    logic [SEL_W-1:0]              held_sel;
    logic [SEL_W-1:0]              prev_sel;
    logic [1:0]                    held_mix;
    logic [ovl_blend_pkg::WT_W-1:0] wt;
    logic [SEL_W-1:0]              sel_a;
    logic [SEL_W-1:0]              sel_b;
    logic [PIX_W-1:0]              held_pix;
    logic [PIX_W-1:0]              mixed;
    logic [SEL_W-1:0]              src_code [NUM_SRC];
    logic [PIX_W-1:0]              src_col  [NUM_SRC];

    // one-beat lookahead: the pixel waiting for its successor
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held_pix <= '0;
        end else if (in_valid) begin
            held_pix <= pix_in;
        end
    end

    ovl_ramp_ctrl #(.SEL_W(SEL_W)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .accept   (in_valid),
        .in_sel   (ovl_sel),
        .in_mix   (mix_code),
        .mode     (mode),
        .held_ok  (held_ok),
        .held_sel (held_sel),
        .prev_sel (prev_sel),
        .held_mix (held_mix),
        .wt       (wt),
        .sel_a    (sel_a),
        .sel_b    (sel_b)
    );

    assign src_code[0] = sel_a;
    assign src_code[1] = sel_b;

    for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
        ovl_color_pick #(
            .COMP_W  (COMP_W),
            .NUM_OVL (NUM_OVL),
            .SEL_W   (SEL_W)
        ) u_pick (
            .code      (src_code[s]),
            .held_pix  (held_pix),
            .color_tbl (ovl_colors),
            .color     (src_col[s])
        );
    end

    for (genvar c = 0; c < NUM_CMP; c++) begin : g_lane
        ovl_mix_lane #(.COMP_W(COMP_W)) u_lane (
            .wt     (wt),
            .comp_a (src_col[0][c*COMP_W +: COMP_W]),
            .comp_b (src_col[1][c*COMP_W +: COMP_W]),
            .comp_y (mixed[c*COMP_W +: COMP_W])
        );
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_pix   <= '0;
        end else begin
            out_valid <= in_valid && held_ok;
            if (in_valid && held_ok) begin
                out_pix <= mixed;
            end
        end
    end

endmodule

// File: rtl/ovl_blend_chk.sv
module ovl_blend_chk #(
    parameter int COMP_W  = 8,
    parameter int NUM_OVL = 7
) (
    input logic                                   clk,
    input logic                                   rst_n,
    input logic                                   in_valid,
    input logic [$clog2(NUM_OVL+1)-1:0]           ovl_sel,
    input logic [1:0]                             mode,
    input logic [NUM_OVL*3*COMP_W-1:0]            ovl_colors,
    input logic                                   out_valid,
    input logic [3*COMP_W-1:0]                    out_pix,
    input logic [3*COMP_W-1:0]                    held_pix,
    input logic [$clog2(NUM_OVL+1)-1:0]           held_sel,
    input logic [$clog2(NUM_OVL+1)-1:0]           prev_sel,
    input logic [1:0]                             held_mix
);
    localparam int PIX_W = 3 * COMP_W;
    localparam int SEL_W = $clog2(NUM_OVL + 1);

    logic [PIX_W-1:0] held_src;
    logic             is_hard;

    always_comb begin
        held_src = held_pix;
        for (int i = 1; i <= NUM_OVL; i++) begin
            if (held_sel == SEL_W'(i)) begin
                held_src = ovl_colors[(i-1)*PIX_W +: PIX_W];
            end
        end
    end

    assign is_hard = (mode == 2'b00) || (mode == 2'b11);

    // R2
    beat_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(in_valid) |-> !out_valid);

    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> $stable(out_pix));

    // R4
    hard_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(is_hard)) |-> (out_pix == $past(held_src)));

    // R5
    ext_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(mode == 2'b01 && held_mix == 2'b00)) |-> (out_pix == $past(held_pix)));

    // R5
    ext_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(mode == 2'b01 && held_mix == 2'b11)) |-> (out_pix == $past(held_src)));

    // R8
    int_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(mode == 2'b10 && held_sel == prev_sel && held_sel == ovl_sel))
            |-> (out_pix == $past(held_src)));

endmodule

bind ovl_blend ovl_blend_chk #(.COMP_W(COMP_W), .NUM_OVL(NUM_OVL)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .ovl_sel    (ovl_sel),
    .mode       (mode),
    .ovl_colors (ovl_colors),
    .out_valid  (out_valid),
    .out_pix    (out_pix),
    .held_pix   (held_pix),
    .held_sel   (held_sel),
    .prev_sel   (prev_sel),
    .held_mix   (held_mix)
);

// File: tb/ovl_blend_tb_top.sv
module ovl_blend_tb_top;
    localparam int W    = 8;
    localparam int NOV  = 7;
    localparam int PW   = 3 * W;
    localparam int MAXP = 4096;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             in_valid = 1'b0;
    logic [PW-1:0]    pix_in = '0;
    logic [2:0]       ovl_sel = '0;
    logic [1:0]       mix_code = '0;
    logic [1:0]       mode = '0;
    logic [NOV*PW-1:0] colors = '0;
    logic             out_valid;
    logic [PW-1:0]    out_pix;

    always #10 clk = ~clk;

    ovl_blend #(.COMP_W(W), .NUM_OVL(NOV)) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .pix_in     (pix_in),
        .ovl_sel    (ovl_sel),
        .mix_code   (mix_code),
        .mode       (mode),
        .ovl_colors (colors),
        .out_valid  (out_valid),
        .out_pix    (out_pix)
    );

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    logic [PW-1:0] m_pix  [MAXP];
    logic [2:0]    m_sel  [MAXP];
    logic [1:0]    m_mix  [MAXP];
    logic [1:0]    m_mode [MAXP];
    logic [PW-1:0] lit    [MAXP];
    bit            lit_ok [MAXP];
    int            acc_n = 0;
    int            out_n = 0;
    bit            exp_ov = 0;
    logic [PW-1:0] last_out = '0;

    function automatic logic [PW-1:0] mixp(int k, logic [PW-1:0] a, logic [PW-1:0] b);
        logic [PW-1:0] r;
        for (int c = 0; c < 3; c++) begin
            int va = int'(a[c*W +: W]);
            int vb = int'(b[c*W +: W]);
            r[c*W +: W] = W'((k * va + (8 - k) * vb + 4) >> 3);
        end
        return r;
    endfunction

    function automatic logic [PW-1:0] src(int n, int s);
        if (s == 0) return m_pix[n];
        return colors[(s-1)*PW +: PW];
    endfunction

    function automatic logic [PW-1:0] expect_px(int n);
        int md = int'(m_mode[n+1]);
        int s  = int'(m_sel[n]);
        int ps = (n == 0) ? 0 : int'(m_sel[n-1]);
        int ns = int'(m_sel[n+1]);
        int k;
        if (md == 1) begin
            case (m_mix[n])
                2'b00: k = 0;
                2'b01: k = 1;
                2'b10: k = 7;
                default: k = 8;
            endcase
            return mixp(k, src(n, s), m_pix[n]);
        end
        if (md == 2) begin
            if (s != ps) return mixp(7, src(n, s), src(n, ps));
            if (s != ns) return mixp(1, src(n, ns), src(n, s));
            return src(n, s);
        end
        return src(n, s);
    endfunction

    function automatic string tag_of(int n);
        int md = int'(m_mode[n+1]);
        int s  = int'(m_sel[n]);
        int ps = (n == 0) ? 0 : int'(m_sel[n-1]);
        if (md == 1) return "R5";
        if (md == 2) begin
            if (s != ps) return "R7";
            if (s != int'(m_sel[n+1])) return "R6";
            return "R8";
        end
        return "R4";
    endfunction

    task automatic check_outputs();
        checks++;
        if (out_valid !== exp_ov) begin
            errors++;
            $display("FAIL R2 out_valid actual %b expected %b", out_valid, exp_ov);
        end
        if (out_valid === 1'b1) begin
            logic [PW-1:0] e = expect_px(out_n);
            checks++;
            if (out_pix !== e) begin
                errors++;
                $display("FAIL %s pixel %0d actual %h expected %h", tag_of(out_n), out_n, out_pix, e);
            end
            if (lit_ok[out_n]) begin
                checks++;
                if (out_pix !== lit[out_n]) begin
                    errors++;
                    $display("FAIL R3 pixel %0d actual %h expected %h", out_n, out_pix, lit[out_n]);
                end
            end
            out_n++;
        end else begin
            checks++;
            if (out_pix !== last_out) begin
                errors++;
                $display("FAIL R2 hold actual %h expected %h", out_pix, last_out);
            end
        end
        last_out = out_pix;
    endtask

    task automatic step(bit v, logic [PW-1:0] p, logic [2:0] s, logic [1:0] m, logic [1:0] md);
        @(negedge clk);
        check_outputs();
        in_valid = v;
        pix_in   = p;
        ovl_sel  = s;
        mix_code = m;
        mode     = md;
        exp_ov   = v && (acc_n > 0);
        if (v && acc_n < MAXP - 2) begin
            m_pix[acc_n]  = p;
            m_sel[acc_n]  = s;
            m_mix[acc_n]  = m;
            m_mode[acc_n] = md;
            acc_n++;
        end
    endtask

    task automatic expect_lit(logic [PW-1:0] v);
        lit[acc_n]    = v;
        lit_ok[acc_n] = 1'b1;
    endtask

    initial begin
        for (int i = 0; i < MAXP; i++) lit_ok[i] = 1'b0;
        void'($urandom(32'h5EED_0F1D));
        for (int i = 0; i < NOV; i++) colors[i*PW +: PW] = PW'($urandom);
        colors[0 +: PW]  = 24'h505050;
        colors[PW +: PW] = 24'h10F080;

        repeat (3) @(negedge clk);
        // R1: reset state
        checks++;
        if (out_valid !== 1'b0 || out_pix !== '0) begin
            errors++;
            $display("FAIL R1 reset actual %b/%h expected 0/000000", out_valid, out_pix);
        end
        rst_n = 1'b1;

        // internal ramp in and out, hand-computed values (R3 R6 R7 R8)
        expect_lit(24'h000000); step(1, 24'h0, 3'd0, 2'd3, 2'b10);
        expect_lit(24'h0A0A0A); step(1, 24'h0, 3'd0, 2'd2, 2'b10);
        expect_lit(24'h464646); step(1, 24'h0, 3'd1, 2'd1, 2'b10);
        expect_lit(24'h505050); step(1, 24'h0, 3'd1, 2'd0, 2'b10);
        step(0, 24'h0, 3'd5, 2'd0, 2'b10);
        expect_lit(24'h464646); step(1, 24'h0, 3'd1, 2'd3, 2'b10);
        expect_lit(24'h0A0A0A); step(1, 24'h0, 3'd0, 2'd2, 2'b10);
        expect_lit(24'h000000); step(1, 24'h0, 3'd0, 2'd1, 2'b10);
        step(1, 24'h0, 3'd0, 2'd0, 2'b10);
        // external ratio codes (R5)
        expect_lit(24'h000000); step(1, 24'h0, 3'd1, 2'd0, 2'b01);
        expect_lit(24'h0A0A0A); step(1, 24'h0, 3'd1, 2'd1, 2'b01);
        expect_lit(24'h464646); step(1, 24'h0, 3'd1, 2'd2, 2'b01);
        expect_lit(24'h505050); step(1, 24'h0, 3'd1, 2'd3, 2'b01);
        expect_lit(24'h123456); step(1, 24'h123456, 3'd0, 2'd3, 2'b01);
        step(1, 24'h0, 3'd0, 2'd0, 2'b01);
        // hard switch, including reserved code 11, single-pixel runs (R4)
        expect_lit(24'h505050); step(1, 24'hABCDEF, 3'd1, 2'd0, 2'b00);
        expect_lit(24'hABCDEF); step(1, 24'hABCDEF, 3'd0, 2'd1, 2'b00);
        expect_lit(24'h10F080); step(1, 24'h777777, 3'd2, 2'd2, 2'b11);
        step(1, 24'h0, 3'd0, 2'd0, 2'b11);
        // internal short runs: settle step takes priority (R7)
        step(1, 24'h202020, 3'd0, 2'd0, 2'b10);
        step(1, 24'h202020, 3'd2, 2'd0, 2'b10);
        step(1, 24'h202020, 3'd0, 2'd0, 2'b10);
        step(1, 24'h202020, 3'd3, 2'd0, 2'b10);
        step(1, 24'h202020, 3'd4, 2'd0, 2'b10);
        step(1, 24'h202020, 3'd4, 2'd0, 2'b10);

        // constrained random segments over all modes
        for (int seg = 0; seg < 8; seg++) begin
            logic [1:0] md = 2'(seg % 4);
            int run_left = 0;
            logic [2:0] cur = 3'd0;
            for (int i = 0; i < 250; i++) begin
                if ($urandom % 4 == 0) begin
                    step(0, PW'($urandom), 3'($urandom), 2'($urandom), md);
                end
                if (md == 2'b10) begin
                    if (run_left == 0) begin
                        if ($urandom % 2 == 0) begin
                            cur = 3'd0;
                            run_left = 1 + int'($urandom % 4);
                        end else begin
                            cur = 3'(1 + $urandom % 7);
                            run_left = 3 + int'($urandom % 4);
                        end
                    end
                    run_left--;
                end else begin
                    cur = 3'($urandom);
                end
                step(1, PW'($urandom), cur, 2'($urandom), md);
            end
        end
        repeat (4) step(0, '0, 3'd0, 2'd0, 2'b00);

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual timeout expected completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule